// File: doc/BRIEF.md
# Flash Status Register Masked Update Sequencer

This block changes chosen bits of the two 8-bit status registers of a serial flash device and leaves the other bits as they were. A client supplies a 16-bit mask, a 16-bit value and a select between a persistent (non-volatile) and a temporary (volatile) update, then pulses a start strobe. The block reads the current 16-bit image over its own SPI master pins. The low register forms bits 7:0 and the high register forms bits 15:8. It merges the requested bits into the image and writes the whole image back in a single write command.

After a persistent write the block polls the device busy flag until it clears. After a temporary write it waits a fixed short interval. It then reads both registers again. If the masked bits did not take the requested values, the device is treated as locked and an error is raised. If the masked bits already hold the requested values, no write is made and the block reports success at once. Each accepted start ends with a one-cycle done pulse, an error flag and the final register image.

The SPI side runs in mode 0: the clock idles low, bits go out most significant first, and the clock runs at clk / (2*SPI_HALF_CYC). Chip select is released between commands.

Top module: `sreg_mask_updater`

## Requirements
- R1: After reset, done and locked_err are 0, sreg_image is 0, spi_cs_n is 1 and spi_sclk is 0.
- R2: An update first sends opcode 0x05 and takes its reply as image bits 7:0. It then sends opcode 0x35, as a separate chip-select frame, and takes its reply as bits 15:8. SPI is mode 0, MSB first, and spi_sclk is low whenever spi_cs_n is high.
- R3: If (value & mask) equals (current & mask), the block sends no write-enable and no write command, ends with locked_err = 0, and sreg_image equals the current image.
- R4: A write is preceded by a one-byte frame carrying opcode 0x06 when nonvolatile = 1, or opcode 0x50 when nonvolatile = 0.
- R5: The write frame is opcode 0x01 followed by the new bits 7:0 and then the new bits 15:8. Here new = (current & ~mask) | (value & mask).
- R6: After a non-volatile write, the block repeats opcode 0x05 reads until reply bit 0 (busy) is 0. If busy is still 1 after NV_TIMEOUT_CYC cycles, it ends with locked_err = 1.
- R7: After a volatile write, chip select stays high for at least VOL_WAIT_CYC cycles before the verification read.
- R8: The block reads both registers back as in R2 and reports them on sreg_image. locked_err is 1 exactly when (readback & mask) differs from (value & mask). locked_err and sreg_image change only in the cycle done is high.
- R9: A start pulse that arrives while an update is in progress is ignored.
- R10: Every accepted start yields exactly one done pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an update (sampled while idle) |
| upd_mask | input | 16 | Bits to be changed |
| upd_value | input | 16 | Requested values for masked bits |
| nonvolatile | input | 1 | 1 = persistent update, 0 = temporary update |
| done | output | 1 | One-cycle completion pulse |
| locked_err | output | 1 | Update did not take effect, or busy timeout |
| sreg_image | output | 16 | Final status image {high, low} |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The hardest situations to reach are the locked outcome and the busy timeout. Both depend on how the device behaves after the write, not on anything the client drives. The bench's serial device model therefore holds a configurable set of write-protected bits that silently keep their old values. This lets the sweep produce masked mismatches on readback. The model also holds a programmable busy duration that can be set longer than the polling limit to force the timeout path. Each sweep trial pairs arithmetic patterns of initial image, mask and value with both write modes and two protection masks. Some patterns are chosen so the masked bits already match, which exercises the skip path.

// File: rtl/sreg_upd_pkg.sv
package sreg_upd_pkg;

  localparam logic [7:0] OPC_READ_LO   = 8'h05;
  localparam logic [7:0] OPC_READ_HI   = 8'h35;
  localparam logic [7:0] OPC_WEN_PERM  = 8'h06;
  localparam logic [7:0] OPC_WEN_TEMP  = 8'h50;
  localparam logic [7:0] OPC_WRITE_SR  = 8'h01;

  typedef enum logic [4:0] {
    SQ_IDLE,
    SQ_CUR_LO_OP, SQ_CUR_LO_DAT,
    SQ_CUR_HI_OP, SQ_CUR_HI_DAT,
    SQ_COMPARE,
    SQ_WEN,
    SQ_WR_OP, SQ_WR_LO, SQ_WR_HI,
    SQ_SETTLE,
    SQ_POLL_OP, SQ_POLL_DAT,
    SQ_CHK_LO_OP, SQ_CHK_LO_DAT,
    SQ_CHK_HI_OP, SQ_CHK_HI_DAT,
    SQ_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    SH_IDLE, SH_LOW, SH_HIGH, SH_GAP
  } shift_state_e;

  function automatic logic is_byte_state(input seq_state_e s);
    case (s)
      SQ_CUR_LO_OP, SQ_CUR_LO_DAT, SQ_CUR_HI_OP, SQ_CUR_HI_DAT,
      SQ_WEN, SQ_WR_OP, SQ_WR_LO, SQ_WR_HI,
      SQ_POLL_OP, SQ_POLL_DAT,
      SQ_CHK_LO_OP, SQ_CHK_LO_DAT, SQ_CHK_HI_OP, SQ_CHK_HI_DAT:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] merge_bits(input logic [15:0] cur,
                                             input logic [15:0] msk,
                                             input logic [15:0] val);
    return (cur & ~msk) | (val & msk);
  endfunction

endpackage

// File: rtl/sreg_spi_byte.sv
module sreg_spi_byte
  import sreg_upd_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       hold_cs,
  output logic       ready,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int PW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [PW-1:0] PH_RELOAD = PW'(HALF_CYC - 1);

  shift_state_e st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          cs_n_q, cs_n_d;
  logic          sclk_q, sclk_d;
  logic          done_q, done_d;
  logic          hold_q, hold_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    cs_n_d = cs_n_q;
    sclk_d = sclk_q;
    hold_d = hold_q;
    done_d = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (go) begin
          cs_n_d = 1'b0;
          tx_d   = tx_byte;
          hold_d = hold_cs;
          bit_d  = 3'd0;
          ph_d   = PH_RELOAD;
          st_d   = SH_LOW;
        end
      end
      SH_LOW: begin
        if (ph_q == '0) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], spi_miso};
          ph_d   = PH_RELOAD;
          st_d   = SH_HIGH;
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      SH_HIGH: begin
        if (ph_q == '0) begin
          sclk_d = 1'b0;
          ph_d   = PH_RELOAD;
          if (bit_q == 3'd7) begin
            done_d = 1'b1;
            if (hold_q) begin
              st_d = SH_IDLE;
            end else begin
              cs_n_d = 1'b1;
              st_d   = SH_GAP;
            end
          end else begin
            tx_d  = {tx_q[6:0], 1'b0};
            bit_d = bit_q + 3'd1;
            st_d  = SH_LOW;
          end
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      SH_GAP: begin
        if (ph_q == '0) st_d = SH_IDLE;
        else            ph_d = ph_q - 1'b1;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      ph_q   <= '0;
      bit_q  <= 3'd0;
      tx_q   <= 8'h00;
      rx_q   <= 8'h00;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cs_n_q <= cs_n_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      hold_q <= hold_d;
    end
  end

  assign ready     = (st_q == SH_IDLE);
  assign byte_done = done_q;
  assign rx_byte   = rx_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = tx_q[7];
endmodule

// File: rtl/sreg_wait_timer.sv
module sreg_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sreg_seq_ctrl.sv
module sreg_seq_ctrl
  import sreg_upd_pkg::*;
#(
  parameter int TW            = 8,
  parameter int NV_TIMEOUT_CYC = 100,
  parameter int VOL_WAIT_CYC   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   upd_mask,
  input  logic [15:0]   upd_value,
  input  logic          nonvolatile,
  input  logic          sh_ready,
  input  logic          sh_done,
  input  logic [7:0]    sh_rx,
  output logic          sh_go,
  output logic [7:0]    sh_tx,
  output logic          sh_hold,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  input  logic          tmr_expired,
  output logic          done,
  output logic          locked_err,
  output logic [15:0]   sreg_image
);
  seq_state_e  st_q, st_d;
  logic        sent_q, sent_d;
  logic [15:0] cur_q, cur_d;
  logic [15:0] msk_q, val_q;
  logic        nv_q;
  logic        req_en;
  logic        err_q, err_d;
  logic [15:0] img_q, img_d;
  logic        res_en;
  logic [15:0] new_img;

  assign new_img = merge_bits(cur_q, msk_q, val_q);

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    err_d    = err_q;
    img_d    = img_q;
    req_en   = 1'b0;
    res_en   = 1'b0;
    sh_tx    = 8'h00;
    sh_hold  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = TW'(VOL_WAIT_CYC);
    case (st_q)
      SQ_IDLE: if (start) begin
        req_en = 1'b1;
        st_d   = SQ_CUR_LO_OP;
      end
      SQ_CUR_LO_OP: begin
        sh_tx = OPC_READ_LO; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_CUR_LO_DAT;
      end
      SQ_CUR_LO_DAT: if (sh_done) begin
        cur_d[7:0] = sh_rx;
        st_d = SQ_CUR_HI_OP;
      end
      SQ_CUR_HI_OP: begin
        sh_tx = OPC_READ_HI; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_CUR_HI_DAT;
      end
      SQ_CUR_HI_DAT: if (sh_done) begin
        cur_d[15:8] = sh_rx;
        st_d = SQ_COMPARE;
      end
      SQ_COMPARE: begin
        if ((val_q & msk_q) == (cur_q & msk_q)) begin
          res_en = 1'b1; err_d = 1'b0; img_d = cur_q;
          st_d = SQ_FINISH;
        end else begin
          st_d = SQ_WEN;
        end
      end
      SQ_WEN: begin
        sh_tx = nv_q ? OPC_WEN_PERM : OPC_WEN_TEMP;
        if (sh_done) st_d = SQ_WR_OP;
      end
      SQ_WR_OP: begin
        sh_tx = OPC_WRITE_SR; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_WR_LO;
      end
      SQ_WR_LO: begin
        sh_tx = new_img[7:0]; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_WR_HI;
      end
      SQ_WR_HI: begin
        sh_tx = new_img[15:8];
        if (sh_done) begin
          tmr_load = 1'b1;
          tmr_val  = nv_q ? TW'(NV_TIMEOUT_CYC) : TW'(VOL_WAIT_CYC);
          st_d     = nv_q ? SQ_POLL_OP : SQ_SETTLE;
        end
      end
      SQ_SETTLE: if (tmr_expired) st_d = SQ_CHK_LO_OP;
      SQ_POLL_OP: begin
        sh_tx = OPC_READ_LO; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_POLL_DAT;
      end
      SQ_POLL_DAT: if (sh_done) begin
        if (!sh_rx[0]) begin
          st_d = SQ_CHK_LO_OP;
        end else if (tmr_expired) begin
          res_en = 1'b1; err_d = 1'b1; img_d = {cur_q[15:8], sh_rx};
          st_d = SQ_FINISH;
        end else begin
          st_d = SQ_POLL_OP;
        end
      end
      SQ_CHK_LO_OP: begin
        sh_tx = OPC_READ_LO; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_CHK_LO_DAT;
      end
      SQ_CHK_LO_DAT: if (sh_done) begin
        cur_d[7:0] = sh_rx;
        st_d = SQ_CHK_HI_OP;
      end
      SQ_CHK_HI_OP: begin
        sh_tx = OPC_READ_HI; sh_hold = 1'b1;
        if (sh_done) st_d = SQ_CHK_HI_DAT;
      end
      SQ_CHK_HI_DAT: if (sh_done) begin
        res_en = 1'b1;
        img_d  = {sh_rx, cur_q[7:0]};
        err_d  = (({sh_rx, cur_q[7:0]} ^ val_q) & msk_q) != 16'h0000;
        st_d   = SQ_FINISH;
      end
      SQ_FINISH: st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    sh_go  = is_byte_state(st_q) && sh_ready && !sent_q;
    sent_d = sent_q;
    if (sh_go)   sent_d = 1'b1;
    if (sh_done) sent_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      sent_q <= 1'b0;
      cur_q  <= 16'h0000;
    end else begin
      st_q   <= st_d;
      sent_q <= sent_d;
      cur_q  <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= 16'h0000;
      val_q <= 16'h0000;
      nv_q  <= 1'b0;
    end else if (req_en) begin
      msk_q <= upd_mask;
      val_q <= upd_value;
      nv_q  <= nonvolatile;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      img_q <= 16'h0000;
    end else if (res_en) begin
      err_q <= err_d;
      img_q <= img_d;
    end
  end

  assign done       = (st_q == SQ_FINISH);
  assign locked_err = err_q;
  assign sreg_image = img_q;
endmodule

// File: rtl/sreg_mask_updater.sv
module sreg_mask_updater #(
  parameter int SPI_HALF_CYC   = 2,
  parameter int NV_TIMEOUT_CYC = 3000000,
  parameter int VOL_WAIT_CYC   = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] upd_mask,
  input  logic [15:0] upd_value,
  input  logic        nonvolatile,
  output logic        done,
  output logic        locked_err,
  output logic [15:0] sreg_image,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int TMR_MAX = (NV_TIMEOUT_CYC > VOL_WAIT_CYC) ? NV_TIMEOUT_CYC : VOL_WAIT_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);

  logic          sh_go, sh_hold, sh_ready, sh_done;
  logic [7:0]    sh_tx, sh_rx;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;

  sreg_seq_ctrl #(
    .TW(TW), .NV_TIMEOUT_CYC(NV_TIMEOUT_CYC), .VOL_WAIT_CYC(VOL_WAIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .upd_mask(upd_mask), .upd_value(upd_value), .nonvolatile(nonvolatile),
    .sh_ready(sh_ready), .sh_done(sh_done), .sh_rx(sh_rx),
    .sh_go(sh_go), .sh_tx(sh_tx), .sh_hold(sh_hold),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_expired(tmr_expired),
    .done(done), .locked_err(locked_err), .sreg_image(sreg_image)
  );

  sreg_spi_byte #(.HALF_CYC(SPI_HALF_CYC)) u_spi (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_tx), .hold_cs(sh_hold),
    .ready(sh_ready), .byte_done(sh_done), .rx_byte(sh_rx),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  sreg_wait_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );
endmodule

// File: rtl/sreg_mask_updater_chk.sv
module sreg_mask_updater_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        locked_err,
  input logic [15:0] sreg_image,
  input logic        spi_cs_n,
  input logic        spi_sclk,
  input logic        spi_mosi
);
  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: serial clock parked low while deselected
  a_r2_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R2: data out held steady through the high clock phase
  a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R8: result flag moves only with done
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked_err) |-> done);

  // R8: result image moves only with done
  a_r8_image_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sreg_image) |-> done);
endmodule

bind sreg_mask_updater sreg_mask_updater_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .locked_err(locked_err),
  .sreg_image(sreg_image), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi)
);

// File: tb/tb_sreg_mask_updater.sv
module tb_sreg_mask_updater;
  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 2;
  localparam int NV_TO  = 3000;
  localparam int VWAIT  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] upd_mask = '0, upd_value = '0;
  logic        nonvolatile = 1'b0;
  logic        done, locked_err, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [15:0] sreg_image;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg_mask_updater #(.SPI_HALF_CYC(HALF), .NV_TIMEOUT_CYC(NV_TO), .VOL_WAIT_CYC(VWAIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .upd_mask(upd_mask),
    .upd_value(upd_value), .nonvolatile(nonvolatile), .done(done),
    .locked_err(locked_err), .sreg_image(sreg_image), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // ---------------- serial device model ----------------
  logic [15:0] m_sr = 16'h0000, m_lock = 16'h0000;
  int   busy_len = 200, busy_cnt = 0, cyc = 0;
  logic cs_q = 1'b1, sclk_q = 1'b0;
  int   bitn = 0, nbytes = 0;
  logic [7:0] in_sh = 0, out_sh = 0, cmd = 0, b1 = 0, b2 = 0;
  bit   wel = 0, wel_v = 0, gap_pending = 0;
  int   wr_cnt = 0, wen_cnt = 0, wr_end_cyc = 0, gap_meas = 0;
  logic [7:0] wen_op = 0, wr_lo = 0, wr_hi = 0;
  logic [7:0] op_log [16];
  int   op_n = 0;

  always @(posedge clk) begin
    cyc++;
    if (busy_cnt > 0) busy_cnt--;
    if (cs_q === 1'b1 && spi_cs_n === 1'b0) begin
      bitn = 0; nbytes = 0; out_sh = 0;
      if (gap_pending) begin gap_meas = cyc - wr_end_cyc; gap_pending = 0; end
    end
    if (spi_cs_n === 1'b0 && !sclk_q && spi_sclk === 1'b1) begin
      in_sh = {in_sh[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (nbytes == 0) begin
          cmd = in_sh;
          if (op_n < 16) op_log[op_n] = in_sh;
          op_n++;
          if (in_sh == 8'h05) out_sh = m_sr[7:0] | {7'b0, busy_cnt > 0};
          else if (in_sh == 8'h35) out_sh = m_sr[15:8];
        end else if (nbytes == 1) b1 = in_sh;
        else if (nbytes == 2) b2 = in_sh;
        nbytes++;
      end
    end
    if (spi_cs_n === 1'b0 && sclk_q && spi_sclk === 1'b0) begin
      spi_miso <= out_sh[7];
      out_sh = {out_sh[6:0], 1'b0};
    end
    if (cs_q === 1'b0 && spi_cs_n === 1'b1) begin
      if (cmd == 8'h06 && nbytes == 1) begin wel = 1; wen_op = cmd; wen_cnt++; end
      if (cmd == 8'h50 && nbytes == 1) begin wel_v = 1; wen_op = cmd; wen_cnt++; end
      if (cmd == 8'h01 && nbytes == 3 && (wel || wel_v)) begin
        wr_cnt++; wr_lo = b1; wr_hi = b2;
        m_sr = ({b2, b1} & ~m_lock) | (m_sr & m_lock);
        if (wel) busy_cnt = busy_len;
        else begin gap_pending = 1; wr_end_cyc = cyc; end
        wel = 0; wel_v = 0;
      end
    end
    cs_q = spi_cs_n; sclk_q = spi_sclk;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [15:0] m, input logic [15:0] v, input bit nv);
    @(negedge clk);
    upd_mask = m; upd_value = v; nonvolatile = nv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done === 1'b1) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic trial(input logic [15:0] init, input logic [15:0] m, input logic [15:0] v,
                       input bit nv, input logic [15:0] lock, input int blen);
    logic [15:0] nw, fin, exp_img;
    bit match, exp_err, tmo, seen;
    int wr0, wen0;
    @(negedge clk);
    m_sr = init; m_lock = lock; busy_len = blen; busy_cnt = 0; op_n = 0;
    gap_meas = 0; gap_pending = 0;
    wr0 = wr_cnt; wen0 = wen_cnt;
    match = ((v & m) == (init & m));
    nw  = (init & ~m) | (v & m);
    fin = (nw & ~lock) | (init & lock);
    tmo = !match && nv && (blen > NV_TO + 200);
    exp_err = match ? 1'b0 : (tmo ? 1'b1 : ((fin & m) != (v & m)));
    exp_img = match ? init : fin;
    pulse_start(m, v, nv);
    wait_done(seen);
    check(seen, "R10 done seen", 32'(seen), 1);
    if (!seen) return;
    check(locked_err === exp_err, "R8/R3/R6 locked_err", 32'(locked_err), 32'(exp_err));
    if (!tmo) check(sreg_image === exp_img, "R8/R3 sreg_image", 32'(sreg_image), 32'(exp_img));
    check(op_log[0] == 8'h05 && op_log[1] == 8'h35, "R2 read order",
          {op_log[0], op_log[1]}, 32'h0535);
    if (match) begin
      check(wr_cnt == wr0 && wen_cnt == wen0, "R3 no write",
            32'(wr_cnt - wr0 + wen_cnt - wen0), 0);
    end else begin
      check(wr_cnt == wr0 + 1, "R5 one write", 32'(wr_cnt - wr0), 1);
      check(wen_op == (nv ? 8'h06 : 8'h50), "R4 enable opcode", 32'(wen_op), nv ? 32'h06 : 32'h50);
      check({wr_hi, wr_lo} == nw, "R5 written bytes", {wr_hi, wr_lo}, 32'(nw));
      if (!nv) check(gap_meas >= VWAIT, "R7 volatile settle", 32'(gap_meas), VWAIT);
      if (nv && !tmo) check(op_n >= 6, "R6 busy polled", 32'(op_n), 6);
    end
    @(negedge clk);
    check(done === 1'b0, "R10 pulse width", 32'(done), 0);
    busy_cnt = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    int extra, wr0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done === 1'b0 && locked_err === 1'b0, "R1 flags", {done, locked_err}, 0);
    check(sreg_image === 16'h0000, "R1 image", 32'(sreg_image), 0);
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 spi idle", {spi_cs_n, spi_sclk}, 32'h2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int mode = 0; mode < 2; mode++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int k = 0; k < 16; k++) begin
          logic [15:0] init, m, v;
          init = (16'(k * 16'h9E37) ^ 16'h5A5A) & 16'hFFFE;
          m    = (k == 0) ? 16'h0000 : (16'(k * 16'h3B1D + 16'h0F0F) & 16'hFFFE);
          v    = 16'(k * 16'h7261) ^ 16'hC3C3;
          if (k == 3 || k == 9) v = init ^ ~m;
          trial(init, m, v, mode[0], lk ? 16'h0C30 : 16'h0000, 200);
        end
      end
    end

    // R6 busy never clears within the limit
    trial(16'h1200, 16'h00F0, 16'h00A0, 1'b1, 16'h0000, 6000);

    // R9 second start while busy is ignored
    @(negedge clk);
    m_sr = 16'h0000; m_lock = 16'h0000; busy_cnt = 0; wr0 = wr_cnt;
    pulse_start(16'h00F0, 16'h0050, 1'b0);
    repeat (60) @(negedge clk);
    start = 1'b1; upd_mask = 16'hFF00; upd_value = 16'hAB00;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    check(seen && sreg_image === 16'h0050, "R9 first request result", 32'(sreg_image), 32'h0050);
    @(negedge clk);
    extra = 0;
    for (int i = 0; i < 1500; i++) begin
      if (done === 1'b1) extra++;
      @(negedge clk);
    end
    check(extra == 0, "R9 no extra done", 32'(extra), 0);
    check(wr_cnt == wr0 + 1, "R9 single write", 32'(wr_cnt - wr0), 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule